// File: doc/BRIEF.md
# In-DRAM Row Copy Command Sequencer

This block sits in a memory controller and turns high-level requests into a timed stream of DRAM commands for a single bank at a time. It handles three request kinds:

- **Plain reads.** A read opens a row and then fetches one bus-width slice of the row buffer.
- **Bulk row copies.** A copy moves an entire row inside the array. It activates the source row, then activates the destination row while the shared row buffer still holds the source data. The buffer then drives that data into the destination. No data crosses the memory bus and no cache is involved.
- **Row initialization.** This is a copy whose source is a reserved all-zero row.

The sequencer tracks which row sits open in the row buffer. A read that hits that row skips activation. A copy whose source is already open skips the source activation. A request for any other row first closes the open row with a precharge.

Three minimum gaps are enforced by down-counters, all counted in clock cycles:

- activate to read (tRCD),
- activate to the next activate or precharge (tRAS),
- precharge to the next activate or completion (tRP).

A request is taken only while the sequencer is idle. Completion is reported with a one-cycle pulse. A copy that names two different banks is refused with a one-cycle error pulse, and no command is issued for it.

Top module: `rowcopy_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `done` and `err` are 0, with no row open.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance and remains 0 until the cycle after `done` or `err`, when it returns to 1.
- R3: A read of a row that is not open (`req_kind` 0) issues ACT (`cmd_type` 1) to `src_bank`/`src_row`. It then issues RD (`cmd_type` 2) with `cmd_col` = `req_col` exactly T_RCD cycles later. `done` follows one cycle after RD, and the row stays open.
- R4: A read of the row already open in the same bank issues RD in the first cycle after acceptance, with no ACT.
- R5: When a different row is open, the first command is PRE (`cmd_type` 3) to the open row's bank. It is issued no earlier than T_RAS cycles after that row's ACT. The next ACT comes exactly T_RP cycles after the PRE.
- R6: A copy (`req_kind` 1) issues the following, with no RD:
  - ACT to the source row,
  - ACT to `dst_row` exactly T_RAS cycles later,
  - PRE exactly T_RAS cycles after that,
  - `done` exactly T_RP cycles after the PRE.
  The copy leaves no row open.
- R7: A copy whose source row is already open in the same bank skips the source ACT. Its destination ACT is issued at the later of the first cycle after acceptance and T_RAS cycles after the source row's ACT.
- R8: An initialization (`req_kind` 2) behaves as a copy in `dst_bank` whose source row is ZERO_ROW (0 in the default build).
- R9: A copy whose `src_bank` differs from `dst_bank` raises `err` for one cycle, in the first cycle after acceptance. It issues no command and leaves the open-row state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 read, 1 copy, 2 initialize |
| src_bank | input | BANK_W | Bank of read or copy source |
| dst_bank | input | BANK_W | Bank of copy or initialize destination |
| src_row | input | ROW_W | Row to read or copy from |
| dst_row | input | ROW_W | Row to copy or initialize into |
| req_col | input | COL_W | Bus-width slice selected by a read |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_type | output | 2 | 0 none, 1 ACT, 2 RD, 3 PRE |
| cmd_bank | output | BANK_W | Bank addressed by the command |
| cmd_row | output | ROW_W | Row of an ACT |
| cmd_col | output | COL_W | Column of an RD |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The bench builds the block with 2 banks and 8 rows. Rows are 64 bits over an 8-bit bus, which gives a 3-bit column. The gaps are T_RCD = 2, T_RAS = 6 and T_RP = 2. With so few rows and banks, every request kind can be swept over every source row and both bank pairs, each followed by a repeat read. That sweep reaches open-row hits, conflicts, matching and mismatching banks, and initialization over the zero row. Because T_RAS is longer than a read's own turnaround, a request arriving right after a read must wait out the remaining activate window, so the delayed precharge and delayed destination activate are both observed. The expected command stream, including the cycle of every command, is derived arithmetically from the three gaps and a model of the open row.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_ACT = 2'd1,
      CMD_RD  = 2'd2,
      CMD_PRE = 2'd3
   } dram_cmd_e;

   typedef enum logic [1:0] {
      REQ_READ = 2'd0,
      REQ_COPY = 2'd1,
      REQ_INIT = 2'd2
   } req_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE_OPEN,
      ST_ACT_FIRST,
      ST_ACT_DST,
      ST_RD,
      ST_PRE_END,
      ST_FIN,
      ST_REJ
   } seq_state_e;

endpackage

// File: rtl/rowcopy_gap_timer.sv
module rowcopy_gap_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (count_q != '0) begin
         count_q <= count_q - CNT_W'(1);
      end
   end

   assign expired = (count_q == '0);

   // R5
   countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));

   // R5
   load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_q == $past(load_val)));

endmodule

// File: rtl/rowcopy_open_row.sv
module rowcopy_open_row #(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic [BANK_W-1:0] set_bank,
   input  logic [ROW_W-1:0]  set_row,
   input  logic              clr,
   input  logic [BANK_W-1:0] q_bank,
   input  logic [ROW_W-1:0]  q_row,
   output logic              open_vld,
   output logic [BANK_W-1:0] open_bank,
   output logic [ROW_W-1:0]  open_row,
   output logic              hit,
   output logic              conflict
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_vld  <= 1'b0;
         open_bank <= '0;
         open_row  <= '0;
      end else if (set) begin
         open_vld  <= 1'b1;
         open_bank <= set_bank;
         open_row  <= set_row;
      end else if (clr) begin
         open_vld  <= 1'b0;
      end
   end

   assign hit      = open_vld && (open_bank == q_bank) && (open_row == q_row);
   assign conflict = open_vld && !hit;

   // R5
   set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set && clr));

   // R6
   clr_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !open_vld);

endmodule

// File: rtl/rowcopy_ctrl.sv
module rowcopy_ctrl
   import rowcopy_pkg::*;
#(
   parameter int BANK_W   = 3,
   parameter int ROW_W    = 16,
   parameter int COL_W    = 9,
   parameter int CNT_W    = 6,
   parameter int T_RCD    = 14,
   parameter int T_RP     = 14,
   parameter int ZERO_ROW = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [BANK_W-1:0] src_bank,
   input  logic [BANK_W-1:0] dst_bank,
   input  logic [ROW_W-1:0]  src_row,
   input  logic [ROW_W-1:0]  dst_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              gap_zero,
   input  logic              ras_zero,
   input  logic              open_hit,
   input  logic              open_conflict,
   input  logic [BANK_W-1:0] open_bank,
   input  logic [ROW_W-1:0]  open_row,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic [1:0]        cmd_type,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic              done,
   output logic              err,
   output logic              gap_load,
   output logic [CNT_W-1:0]  gap_val,
   output logic              ras_load,
   output logic              or_set,
   output logic [ROW_W-1:0]  or_set_row,
   output logic              or_clr,
   output logic [BANK_W-1:0] q_bank,
   output logic [ROW_W-1:0]  q_row
);

   localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
   localparam logic [ROW_W-1:0] ZROW    = ROW_W'(ZERO_ROW);

   seq_state_e        state_q, state_d;
   logic              r_is_read;
   logic [BANK_W-1:0] r_bank;
   logic [ROW_W-1:0]  r_tgt;
   logic [ROW_W-1:0]  r_dst;
   logic [COL_W-1:0]  r_col;

   logic in_is_copy, in_is_init, in_is_read, in_bad_bank;

   assign in_is_copy  = (req_kind == REQ_COPY);
   assign in_is_init  = (req_kind == REQ_INIT);
   assign in_is_read  = !(in_is_copy || in_is_init);
   assign in_bad_bank = in_is_copy && (src_bank != dst_bank);
   assign q_bank      = in_is_init ? dst_bank : src_bank;
   assign q_row       = in_is_init ? ZROW : src_row;
   assign req_ready   = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         r_is_read <= 1'b0;
         r_bank    <= '0;
         r_tgt     <= '0;
         r_dst     <= '0;
         r_col     <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            r_is_read <= in_is_read;
            r_bank    <= q_bank;
            r_tgt     <= q_row;
            r_dst     <= dst_row;
            r_col     <= req_col;
         end
      end
   end

   always_comb begin
      state_d    = state_q;
      cmd_valid  = 1'b0;
      cmd_type   = CMD_NOP;
      cmd_bank   = r_bank;
      cmd_row    = r_tgt;
      cmd_col    = r_col;
      done       = 1'b0;
      err        = 1'b0;
      gap_load   = 1'b0;
      gap_val    = '0;
      ras_load   = 1'b0;
      or_set     = 1'b0;
      or_set_row = r_tgt;
      or_clr     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (in_bad_bank)        state_d = ST_REJ;
               else if (open_conflict) state_d = ST_PRE_OPEN;
               else if (open_hit)      state_d = in_is_read ? ST_RD : ST_ACT_DST;
               else                    state_d = ST_ACT_FIRST;
            end
         end
         ST_PRE_OPEN: begin
            if (gap_zero && ras_zero) begin
               cmd_valid = 1'b1;
               cmd_type  = CMD_PRE;
               cmd_bank  = open_bank;
               cmd_row   = open_row;
               gap_load  = 1'b1;
               gap_val   = LD_RP;
               or_clr    = 1'b1;
               state_d   = ST_ACT_FIRST;
            end
         end
         ST_ACT_FIRST: begin
            if (gap_zero) begin
               cmd_valid = 1'b1;
               cmd_type  = CMD_ACT;
               or_set    = 1'b1;
               ras_load  = 1'b1;
               gap_load  = 1'b1;
               gap_val   = r_is_read ? LD_RCD : '0;
               state_d   = r_is_read ? ST_RD : ST_ACT_DST;
            end
         end
         ST_ACT_DST: begin
            if (gap_zero && ras_zero) begin
               cmd_valid  = 1'b1;
               cmd_type   = CMD_ACT;
               cmd_row    = r_dst;
               or_set     = 1'b1;
               or_set_row = r_dst;
               ras_load   = 1'b1;
               state_d    = ST_PRE_END;
            end
         end
         ST_RD: begin
            if (gap_zero) begin
               cmd_valid = 1'b1;
               cmd_type  = CMD_RD;
               state_d   = ST_FIN;
            end
         end
         ST_PRE_END: begin
            if (gap_zero && ras_zero) begin
               cmd_valid = 1'b1;
               cmd_type  = CMD_PRE;
               gap_load  = 1'b1;
               gap_val   = LD_RP;
               or_clr    = 1'b1;
               state_d   = ST_FIN;
            end
         end
         ST_FIN: begin
            if (gap_zero) begin
               done    = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_REJ: begin
            err     = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2
   done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> req_ready);

   // R9
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!cmd_valid && !done && !or_set && !or_clr));

endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
   import rowcopy_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int NUM_ROWS  = 65536,
   parameter int ROW_BITS  = 4096,
   parameter int BUS_W     = 8,
   parameter int T_RCD     = 14,
   parameter int T_RAS     = 34,
   parameter int T_RP      = 14,
   parameter int ZERO_ROW  = 0,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int ROW_W    = $clog2(NUM_ROWS),
   localparam int COL_W    = $clog2(ROW_BITS / BUS_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [BANK_W-1:0] src_bank,
   input  logic [BANK_W-1:0] dst_bank,
   input  logic [ROW_W-1:0]  src_row,
   input  logic [ROW_W-1:0]  dst_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              cmd_valid,
   output logic [1:0]        cmd_type,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic              done,
   output logic              err
);

   localparam int MAXT_A = (T_RCD > T_RAS) ? T_RCD : T_RAS;
   localparam int MAXT   = (MAXT_A > T_RP) ? MAXT_A : T_RP;
   localparam int CNT_W  = $clog2(MAXT + 1);
   localparam int NTMR   = 2;
   localparam int TMR_GAP = 0;
   localparam int TMR_RAS = 1;

   if (NUM_BANKS < 2 || NUM_ROWS < 2) begin : g_bad_geom
      $error("rowcopy_seq: needs at least two banks and two rows");
   end
   if (BUS_W < 1 || ROW_BITS % BUS_W != 0 || ROW_BITS / BUS_W < 2) begin : g_bad_width
      $error("rowcopy_seq: row width must be a multiple of the bus width");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RP < 1) begin : g_bad_timing
      $error("rowcopy_seq: timing gaps must be at least one cycle");
   end
   if (ZERO_ROW < 0 || ZERO_ROW >= NUM_ROWS) begin : g_bad_zero
      $error("rowcopy_seq: reserved zero row out of range");
   end

   logic              gap_load, ras_load;
   logic [CNT_W-1:0]  gap_val;
   logic [NTMR-1:0]   t_load;
   logic [CNT_W-1:0]  t_val [NTMR];
   logic [NTMR-1:0]   t_zero;
   logic              or_set, or_clr, open_vld, open_hit, open_conflict;
   logic [ROW_W-1:0]  or_set_row, open_row, q_row;
   logic [BANK_W-1:0] open_bank, q_bank;

   assign t_load[TMR_GAP] = gap_load;
   assign t_val[TMR_GAP]  = gap_val;
   assign t_load[TMR_RAS] = ras_load;
   assign t_val[TMR_RAS]  = CNT_W'(T_RAS - 1);

   for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      rowcopy_gap_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (t_load[i]),
         .load_val (t_val[i]),
         .expired  (t_zero[i])
      );
   end

   rowcopy_open_row #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_open (
      .clk       (clk),
      .rst_n     (rst_n),
      .set       (or_set),
      .set_bank  (cmd_bank),
      .set_row   (or_set_row),
      .clr       (or_clr),
      .q_bank    (q_bank),
      .q_row     (q_row),
      .open_vld  (open_vld),
      .open_bank (open_bank),
      .open_row  (open_row),
      .hit       (open_hit),
      .conflict  (open_conflict)
   );

   rowcopy_ctrl #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W),
      .T_RCD(T_RCD), .T_RP(T_RP), .ZERO_ROW(ZERO_ROW)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_kind      (req_kind),
      .src_bank      (src_bank),
      .dst_bank      (dst_bank),
      .src_row       (src_row),
      .dst_row       (dst_row),
      .req_col       (req_col),
      .gap_zero      (t_zero[TMR_GAP]),
      .ras_zero      (t_zero[TMR_RAS]),
      .open_hit      (open_hit),
      .open_conflict (open_conflict),
      .open_bank     (open_bank),
      .open_row      (open_row),
      .req_ready     (req_ready),
      .cmd_valid     (cmd_valid),
      .cmd_type      (cmd_type),
      .cmd_bank      (cmd_bank),
      .cmd_row       (cmd_row),
      .cmd_col       (cmd_col),
      .done          (done),
      .err           (err),
      .gap_load      (gap_load),
      .gap_val       (gap_val),
      .ras_load      (ras_load),
      .or_set        (or_set),
      .or_set_row    (or_set_row),
      .or_clr        (or_clr),
      .q_bank        (q_bank),
      .q_row         (q_row)
   );

   // Independent gap observers for the command stream
   localparam int SW = CNT_W + 1;
   logic [SW-1:0] since_act, since_pre;
   logic          act_seen, pre_seen;
   logic          is_act, is_pre, is_rd;

   assign is_act = cmd_valid && (cmd_type == CMD_ACT);
   assign is_pre = cmd_valid && (cmd_type == CMD_PRE);
   assign is_rd  = cmd_valid && (cmd_type == CMD_RD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '0;
         since_pre <= '0;
         act_seen  <= 1'b0;
         pre_seen  <= 1'b0;
      end else begin
         if (is_act) begin
            since_act <= SW'(1);
            act_seen  <= 1'b1;
         end else if (since_act != '1) begin
            since_act <= since_act + SW'(1);
         end
         if (is_pre) begin
            since_pre <= SW'(1);
            pre_seen  <= 1'b1;
         end else if (since_pre != '1) begin
            since_pre <= since_pre + SW'(1);
         end
      end
   end

   // R3
   rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |-> (act_seen && since_act >= SW'(T_RCD)));

   // R5
   ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (act_seen && since_act >= SW'(T_RAS)));

   // R5
   rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && pre_seen) |-> (since_pre >= SW'(T_RP)));

   // R6
   done_after_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cmd_valid && (!pre_seen || since_pre >= SW'(T_RP)
                               || since_act < since_pre)));

   // R1
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, done, err}));

endmodule

// File: tb/rowcopy_seq_bench.sv
module rowcopy_seq_bench;

   localparam int NB   = 2;
   localparam int NR   = 8;
   localparam int RB   = 64;
   localparam int BW   = 8;
   localparam int TRCD = 2;
   localparam int TRAS = 6;
   localparam int TRP  = 2;
   localparam int ZR   = 0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_kind = '0;
   logic [0:0] src_bank = '0, dst_bank = '0;
   logic [2:0] src_row = '0, dst_row = '0, req_col = '0;
   logic       cmd_valid;
   logic [1:0] cmd_type;
   logic [0:0] cmd_bank;
   logic [2:0] cmd_row, cmd_col;
   logic       done, err;

   always #4 clk = ~clk;

   rowcopy_seq #(
      .NUM_BANKS(NB), .NUM_ROWS(NR), .ROW_BITS(RB), .BUS_W(BW),
      .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP), .ZERO_ROW(ZR)
   ) u_rowcopy_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .src_bank(src_bank), .dst_bank(dst_bank),
      .src_row(src_row), .dst_row(dst_row), .req_col(req_col),
      .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
      .cmd_row(cmd_row), .cmd_col(cmd_col), .done(done), .err(err)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int lg_n = 0, done_c = -1, err_c = -1;
   int lg_cyc [16];
   int lg_typ [16];
   int lg_bank[16];
   int lg_arg [16];

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid && lg_n < 16) begin
            lg_cyc[lg_n]  = cyc;
            lg_typ[lg_n]  = int'(cmd_type);
            lg_bank[lg_n] = int'(cmd_bank);
            lg_arg[lg_n]  = (cmd_type == 2'd2) ? int'(cmd_col) : int'(cmd_row);
            lg_n = lg_n + 1;
         end
         if (done) done_c = cyc;
         if (err)  err_c  = cyc;
      end
   end

   int checks = 0, failures = 0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // bench model of the open row
   int m_open = 0, m_bank = 0, m_row = 0, m_last_act = -1000;

   task automatic do_req(int kind, int sb, int db, int sr, int dr, int col);
      int A, t, bank, tgt, e_done, guard, n;
      bit hit, rej, conf;
      int e_cyc[8];
      int e_typ[8];
      int e_bank[8];
      int e_arg[8];
      string tag;
      n = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_kind  = 2'(kind);
      src_bank  = 1'(sb);
      dst_bank  = 1'(db);
      src_row   = 3'(sr);
      dst_row   = 3'(dr);
      req_col   = 3'(col);
      req_valid = 1'b1;
      lg_n = 0; done_c = -1; err_c = -1;
      @(negedge clk);
      A = cyc;
      req_valid = 1'b0;
      chk("R2", "ready low after acceptance", int'(req_ready), 0);

      rej = (kind == 1) && (sb != db);
      bank = (kind == 2) ? db : sb;
      tgt  = (kind == 2) ? ZR : sr;
      hit  = (m_open != 0) && m_bank == bank && m_row == tgt;
      conf = (m_open != 0) && !hit;
      e_done = -1;
      t = A;
      if (!rej) begin
         if (conf) begin
            if (m_last_act + TRAS > t) t = m_last_act + TRAS;
            e_cyc[n] = t; e_typ[n] = 3; e_bank[n] = m_bank; e_arg[n] = -1; n++;
            m_open = 0;
            t = t + TRP;
         end
         if (kind == 0) begin
            if (!hit) begin
               e_cyc[n] = t; e_typ[n] = 1; e_bank[n] = bank; e_arg[n] = tgt; n++;
               m_last_act = t; m_open = 1; m_bank = bank; m_row = tgt;
               t = t + TRCD;
            end
            e_cyc[n] = t; e_typ[n] = 2; e_bank[n] = bank; e_arg[n] = col; n++;
            e_done = t + 1;
         end else begin
            if (!hit) begin
               e_cyc[n] = t; e_typ[n] = 1; e_bank[n] = bank; e_arg[n] = tgt; n++;
               m_last_act = t;
               t = t + TRAS;
            end else if (m_last_act + TRAS > t) begin
               t = m_last_act + TRAS;
            end
            e_cyc[n] = t; e_typ[n] = 1; e_bank[n] = bank; e_arg[n] = dr; n++;
            m_last_act = t;
            t = t + TRAS;
            e_cyc[n] = t; e_typ[n] = 3; e_bank[n] = bank; e_arg[n] = -1; n++;
            m_open = 0;
            e_done = t + TRP;
         end
      end

      guard = 0;
      while (done_c < 0 && err_c < 0 && guard < 300) begin
         @(posedge clk);
         guard++;
      end
      @(negedge clk);

      if (kind == 0) tag = hit ? "R4" : "R3";
      else if (kind == 1) tag = rej ? "R9" : (hit ? "R7" : "R6");
      else tag = "R8";

      if (rej) begin
         chk("R9", "err cycle", err_c, A);
         chk("R9", "commands on reject", lg_n, 0);
         chk("R9", "done on reject", done_c, -1);
         chk("R2", "ready after err", int'(req_ready), 1);
      end else begin
         chk(tag, "command count", lg_n, n);
         for (int i = 0; i < n && i < lg_n; i++) begin
            string ctag;
            ctag = (conf && i == 0) ? "R5" : tag;
            chk(ctag, $sformatf("cmd %0d type", i), lg_typ[i], e_typ[i]);
            chk(ctag, $sformatf("cmd %0d cycle", i), lg_cyc[i], e_cyc[i]);
            chk(ctag, $sformatf("cmd %0d bank", i), lg_bank[i], e_bank[i]);
            if (e_arg[i] >= 0)
               chk(ctag, $sformatf("cmd %0d row/col", i), lg_arg[i], e_arg[i]);
         end
         chk(tag, "done cycle", done_c, e_done);
         chk("R2", "ready after done", int'(req_ready), 1);
         chk("R2", "ready cycle", cyc, e_done + 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", int'(req_ready), 1);
      chk("R1", "cmd_valid after reset", int'(cmd_valid), 0);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "err after reset", int'(err), 0);

      // R3 cold read, R4 repeat hit, R5 conflict delayed by the activate window
      do_req(0, 0, 0, 2, 0, 5);
      do_req(0, 0, 0, 2, 0, 1);
      do_req(0, 0, 0, 3, 0, 4);
      // R7 copy from the open row, delayed destination activate
      do_req(1, 0, 0, 3, 6, 0);
      // R9 rejection keeps the open row: next read is a hit
      do_req(0, 1, 1, 5, 0, 2);
      do_req(1, 1, 0, 5, 6, 0);
      do_req(0, 1, 1, 5, 0, 3);
      // R8 initialization of a row, then with the zero row open
      do_req(2, 0, 1, 0, 4, 0);
      do_req(0, 1, 1, ZR, 0, 0);
      do_req(2, 0, 1, 0, 7, 0);

      // sweep: every kind, both bank pairs, every source row
      for (int k = 0; k < 3; k++)
         for (int sb = 0; sb < NB; sb++)
            for (int db = 0; db < NB; db++)
               for (int sr = 0; sr < NR; sr++) begin
                  do_req(k, sb, db, sr, (sr + 3) % NR, sr);
                  do_req(0, sb, sb, sr, 0, NR - 1 - sr);
               end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule